// File: doc/BRIEF.md
# ADC Self-Calibration Sequencer

This block sequences the self-calibration phase of an analog-to-digital converter. Software requests a calibration by writing a one to the calibrate bit. The block holds that request until the converter is powered and has had a qualifying power-down period before it. It then runs a calibration phase of fixed length. During the phase it walks a per-capacitor measurement model and captures one correction code for each capacitor of the internal array. When the phase ends, the calibrate bit clears itself and the packed codes appear in the data register.

The controller is built around a three-state machine. The states are `CAL_IDLE` (no request), `CAL_WAIT` (request pending, waiting for the power qualification) and `CAL_RUN` (calibration in progress). There are four transitions:
- T_REQ (`CAL_IDLE`→`CAL_WAIT`): a software set pulse.
- T_GO (`CAL_WAIT`→`CAL_RUN`): power is on and the power-off qualification is met; starting the phase consumes the qualification.
- T_DONE (`CAL_RUN`→`CAL_IDLE`): the last measurement slot is reached with power still on; the data register is loaded.
- T_ABORT (`CAL_RUN`→`CAL_IDLE`): power is removed during the phase; the data register is left untouched.

Every other case holds the current state. Conversion-start requests pass to the converter only while it is powered and not calibrating.

Top module: `adc_selfcal_ctrl`

## Requirements
- R1: After reset, `cal_bit`, `cal_busy`, `cap_sample` and `conv_go` are 0 and `dr_value` is all zeros.
- R2: A one-cycle `cal_set` pulse makes `cal_bit` read 1 from the next cycle. `cal_bit` stays 1 until the calibration finishes or is aborted, and it is 1 whenever `cal_busy` is 1.
- R3: Calibration (`cal_busy` high) starts only while `power_on` is 1, and only if `power_on` was sampled 0 on at least OFF_MIN (default 2) consecutive clocks since reset or since the previous calibration start. A request that does not meet this condition stays pending with `cal_bit`=1 and `cal_busy`=0.
- R4: If the request is already qualified, `cal_busy` rises one cycle after `cal_bit` rises. Without an abort, `cal_busy` then stays high for exactly NUM_CAPS×SLOT_CYCLES consecutive clocks.
- R5: During the phase, `cap_sel` steps through 0 to NUM_CAPS-1 in ascending order and holds each value for SLOT_CYCLES clocks. `cap_sample` pulses on the last clock of each slot, and the block captures `cap_code` on that clock.
- R6: In the cycle after the last busy cycle of a completed phase, `cal_bit` is 0. In that same cycle `dr_value` holds the captured codes, with the code of capacitor i at bits [i×CODE_W +: CODE_W]. `dr_value` changes at no other time.
- R7: `conv_go` equals `conv_req` while `power_on` is 1 and `cal_busy` is 0. It is 0 while calibration is in progress or power is off.
- R8: If `power_on` is 0 in any busy cycle, the next cycle has `cal_busy`=0 and `cal_bit`=0, and `dr_value` is unchanged. This holds even in the final busy cycle, where the abort wins over the data-register load.
- R9: A `cal_set` pulse while `cal_bit` is already 1 is ignored: the running phase keeps its length and no second phase follows.
- R10: A pending request survives a power-down. It starts on the first powered clock after OFF_MIN off clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_on | input | 1 | Converter power-on enable bit |
| cal_set | input | 1 | Software write of 1 to the calibrate bit (one-cycle pulse) |
| conv_req | input | 1 | Conversion-start request |
| cap_code | input | CODE_W | Code returned by the measurement model for `cap_sel` |
| cal_bit | output | 1 | Calibrate bit readback (self-clearing) |
| cal_busy | output | 1 | Calibration in progress |
| conv_go | output | 1 | Conversion start passed to the converter |
| cap_sel | output | $clog2(NUM_CAPS) | Capacitor currently measured |
| cap_sample | output | 1 | Capture strobe for `cap_code` |
| dr_value | output | NUM_CAPS×CODE_W | Data register holding packed correction codes |

## Verification
Two events can fall on the same clock edge. One is the loading of the data register on the final calibration cycle; the other is an abort caused by power removal. The bench counts exactly to the last busy cycle, confirms there that `cap_sample` is high, drops `power_on` in that cycle, and requires the old data-register contents and a cleared calibrate bit on the next cycle. A second collision comes from a held conversion request across the whole phase: `conv_go` must stay 0 on every busy cycle and reappear on the first idle cycle.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_WAIT = 2'd1,
        CAL_RUN  = 2'd2
    } cal_state_e;

endpackage

// File: rtl/adc_pwroff_qual.sv
// Tracks whether the converter has been powered down long enough
// to allow the next calibration phase to begin.
module adc_pwroff_qual #(
    parameter int OFF_MIN = 2,
    localparam int OW = $clog2(OFF_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_on,
    input  logic consume,
    output logic qualified
);

    logic [OW-1:0] off_cnt;
    logic          qual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= '0;
            qual_q  <= 1'b0;
        end else if (!power_on) begin
            if (int'(off_cnt) < OFF_MIN) begin
                off_cnt <= off_cnt + OW'(1);
            end
            if (int'(off_cnt) + 1 >= OFF_MIN) begin
                qual_q <= 1'b1;
            end
        end else begin
            off_cnt <= '0;
            if (consume) begin
                qual_q <= 1'b0;
            end
        end
    end

    assign qualified = qual_q;

endmodule

// File: rtl/adc_cal_seq.sv
// Slot and capacitor counters for the calibration phase.
module adc_cal_seq #(
    parameter int NUM_CAPS    = 4,
    parameter int SLOT_CYCLES = 6,
    localparam int IDX_W = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1,
    localparam int SW    = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [IDX_W-1:0] cap_idx,
    output logic             sample,
    output logic             last
);

    logic [SW-1:0]    slot_cnt;
    logic [IDX_W-1:0] idx_q;
    logic             slot_end;

    assign slot_end = run && (slot_cnt == SW'(SLOT_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            idx_q    <= '0;
        end else if (!run) begin
            slot_cnt <= '0;
            idx_q    <= '0;
        end else if (slot_end) begin
            slot_cnt <= '0;
            if (idx_q != IDX_W'(NUM_CAPS - 1)) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end else begin
            slot_cnt <= slot_cnt + SW'(1);
        end
    end

    assign cap_idx = idx_q;
    assign sample  = slot_end;
    assign last    = slot_end && (idx_q == IDX_W'(NUM_CAPS - 1));

endmodule

// File: rtl/adc_cal_codebank.sv
// One correction-code register per capacitor; exposes the packed
// contents including a write landing on the current edge.
module adc_cal_codebank #(
    parameter int NUM_CAPS = 4,
    parameter int CODE_W   = 4,
    localparam int IDX_W = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [IDX_W-1:0]           idx,
    input  logic [CODE_W-1:0]          din,
    output logic [NUM_CAPS*CODE_W-1:0] packed_next
);

    for (genvar g = 0; g < NUM_CAPS; g++) begin : g_entry
        logic [CODE_W-1:0] code_q;
        logic              hit;

        assign hit = wr && (idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (hit) begin
                code_q <= din;
            end
        end

        assign packed_next[g*CODE_W +: CODE_W] = hit ? din : code_q;
    end

endmodule

// File: rtl/adc_selfcal_ctrl.sv
module adc_selfcal_ctrl
    import adc_cal_pkg::*;
#(
    parameter int NUM_CAPS    = 4,
    parameter int CODE_W      = 4,
    parameter int SLOT_CYCLES = 6,
    parameter int OFF_MIN     = 2,
    localparam int IDX_W = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1,
    localparam int DR_W  = NUM_CAPS * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_on,
    input  logic              cal_set,
    input  logic              conv_req,
    input  logic [CODE_W-1:0] cap_code,
    output logic              cal_bit,
    output logic              cal_busy,
    output logic              conv_go,
    output logic [IDX_W-1:0]  cap_sel,
    output logic              cap_sample,
    output logic [DR_W-1:0]   dr_value
);

    cal_state_e      state_q, state_d;
    logic            qualified;
    logic            consume;
    logic            run;
    logic            seq_sample;
    logic            seq_last;
    logic            commit;
    logic [DR_W-1:0] bank_packed;
    logic [DR_W-1:0] dr_q;

    adc_pwroff_qual #(.OFF_MIN(OFF_MIN)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .power_on  (power_on),
        .consume   (consume),
        .qualified (qualified)
    );

    adc_cal_seq #(.NUM_CAPS(NUM_CAPS), .SLOT_CYCLES(SLOT_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cap_idx (cap_sel),
        .sample  (seq_sample),
        .last    (seq_last)
    );

    adc_cal_codebank #(.NUM_CAPS(NUM_CAPS), .CODE_W(CODE_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (seq_sample),
        .idx         (cap_sel),
        .din         (cap_code),
        .packed_next (bank_packed)
    );

    // Next-state logic: T_REQ, T_GO, T_DONE, T_ABORT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE: if (cal_set) state_d = CAL_WAIT;
            CAL_WAIT: if (power_on && qualified) state_d = CAL_RUN;
            CAL_RUN: begin
                if (!power_on)     state_d = CAL_IDLE;
                else if (seq_last) state_d = CAL_IDLE;
            end
            default: state_d = CAL_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        cal_bit = 1'b0;
        run     = 1'b0;
        consume = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            CAL_IDLE: ;
            CAL_WAIT: begin
                cal_bit = 1'b1;
                consume = power_on && qualified;
            end
            CAL_RUN: begin
                cal_bit = 1'b1;
                run     = 1'b1;
                commit  = power_on && seq_last;
            end
            default: ;
        endcase
    end

    // Data register: loaded only by a completed phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dr_q <= '0;
        else if (commit) dr_q <= bank_packed;
    end

    assign cal_busy   = run;
    assign cap_sample = seq_sample;
    assign conv_go    = conv_req && power_on && !run;
    assign dr_value   = dr_q;

endmodule

// File: rtl/adc_selfcal_ctrl_chk.sv
module adc_selfcal_ctrl_chk #(
    parameter int NUM_CAPS    = 4,
    parameter int CODE_W      = 4,
    parameter int SLOT_CYCLES = 6,
    localparam int CAL_CYCLES = NUM_CAPS * SLOT_CYCLES,
    localparam int RW         = $clog2(CAL_CYCLES + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       power_on,
    input logic                       cal_bit,
    input logic                       cal_busy,
    input logic                       conv_go,
    input logic                       cap_sample,
    input logic [NUM_CAPS*CODE_W-1:0] dr_value
);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          run_len <= '0;
        else if (!cal_busy)                  run_len <= '0;
        else if (run_len != RW'(CAL_CYCLES)) run_len <= run_len + RW'(1);
    end

    assert_busy_has_cal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> cal_bit);

    assert_start_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_bit |=> !cal_busy);

    assert_phase_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (run_len < RW'(CAL_CYCLES)));

    assert_sample_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_sample |-> cal_busy);

    assert_dr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |=> $stable(dr_value));

    assert_no_conv_in_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !conv_go);

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && !power_on) |=> (!cal_busy && !cal_bit && $stable(dr_value)));

endmodule

bind adc_selfcal_ctrl adc_selfcal_ctrl_chk #(
    .NUM_CAPS    (NUM_CAPS),
    .CODE_W      (CODE_W),
    .SLOT_CYCLES (SLOT_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_on   (power_on),
    .cal_bit    (cal_bit),
    .cal_busy   (cal_busy),
    .conv_go    (conv_go),
    .cap_sample (cap_sample),
    .dr_value   (dr_value)
);

// File: tb/adc_selfcal_ctrl_bench.sv
module adc_selfcal_ctrl_bench;

    localparam int NUM_CAPS    = 4;
    localparam int CODE_W      = 4;
    localparam int SLOT_CYCLES = 6;
    localparam int CAL         = NUM_CAPS * SLOT_CYCLES;
    localparam int IDX_W       = $clog2(NUM_CAPS);
    localparam int DR_W        = NUM_CAPS * CODE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              power_on = 1'b0;
    logic              cal_set = 1'b0;
    logic              conv_req = 1'b0;
    logic [CODE_W-1:0] cap_code;
    logic              cal_bit, cal_busy, conv_go, cap_sample;
    logic [IDX_W-1:0]  cap_sel;
    logic [DR_W-1:0]   dr_value;

    int n_chk  = 0;
    int n_fail = 0;
    int salt   = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    // Stub measurement model.
    assign cap_code = CODE_W'(int'(cap_sel) * 5 + salt);

    adc_selfcal_ctrl #(
        .NUM_CAPS(NUM_CAPS), .CODE_W(CODE_W), .SLOT_CYCLES(SLOT_CYCLES), .OFF_MIN(2)
    ) u_adc_selfcal_ctrl (
        .clk(clk), .rst_n(rst_n), .power_on(power_on), .cal_set(cal_set),
        .conv_req(conv_req), .cap_code(cap_code), .cal_bit(cal_bit),
        .cal_busy(cal_busy), .conv_go(conv_go), .cap_sel(cap_sel),
        .cap_sample(cap_sample), .dr_value(dr_value)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [DR_W-1:0] exp_dr(input int s);
        logic [DR_W-1:0] r;
        for (int i = 0; i < NUM_CAPS; i++) r[i*CODE_W +: CODE_W] = CODE_W'(i * 5 + s);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic power_cycle(input int n);
        power_on = 1'b0;
        repeat (n) step();
        power_on = 1'b1;
    endtask

    task automatic pulse_set;
        cal_set = 1'b1;
        step();
        cal_set = 1'b0;
    endtask

    // Called while cal_busy is observed high; returns at first idle cycle.
    task automatic measure(output int len, output int nsamp, output int bad_order, output int leak);
        len = 0; nsamp = 0; bad_order = 0; leak = 0;
        while (cal_busy === 1'b1 && len < 1000) begin
            if (cap_sample) begin
                if (int'(cap_sel) != nsamp) bad_order++;
                nsamp++;
            end
            if (conv_go) leak++;
            len++;
            step();
        end
    endtask

    task automatic t_reset;
        step();
        chk("R1 cal_bit", 32'(cal_bit), 0);
        chk("R1 cal_busy", 32'(cal_busy), 0);
        chk("R1 cap_sample", 32'(cap_sample), 0);
        chk("R1 dr_value", 32'(dr_value), 0);
        conv_req = 1'b1;
        #1;
        chk("R1/R7 conv_go with power off", 32'(conv_go), 0);
        conv_req = 1'b0;
    endtask

    task automatic t_basic;
        int len, ns, bo, lk;
        salt = 1;
        power_cycle(2);
        pulse_set();
        chk("R2 cal_bit set", 32'(cal_bit), 1);
        chk("R4 busy not yet", 32'(cal_busy), 0);
        conv_req = 1'b1;
        step();
        chk("R4 busy starts", 32'(cal_busy), 1);
        measure(len, ns, bo, lk);
        chk("R4 phase length", 32'(len), 32'(CAL));
        chk("R5 sample count", 32'(ns), 32'(NUM_CAPS));
        chk("R5 capacitor order", 32'(bo), 0);
        chk("R7 conv blocked in phase", 32'(lk), 0);
        chk("R6 cal_bit cleared", 32'(cal_bit), 0);
        chk("R6 dr codes", 32'(dr_value), 32'(exp_dr(1)));
        chk("R7 conv passes after phase", 32'(conv_go), 1);
        conv_req = 1'b0;
    endtask

    task automatic t_pending;
        int len, ns, bo, lk;
        salt = 2;
        pulse_set();
        repeat (8) step();
        chk("R3 pending cal_bit", 32'(cal_bit), 1);
        chk("R3 no start without off period", 32'(cal_busy), 0);
        power_cycle(1);
        repeat (4) step();
        chk("R3 one off cycle not enough", 32'(cal_busy), 0);
        power_on = 1'b0;
        step(); step();
        chk("R10 pending through power-down", 32'(cal_bit), 1);
        chk("R10 idle while off", 32'(cal_busy), 0);
        power_on = 1'b1;
        step();
        chk("R10 starts on power-up", 32'(cal_busy), 1);
        measure(len, ns, bo, lk);
        chk("R4 phase length after pend", 32'(len), 32'(CAL));
        chk("R6 dr codes after pend", 32'(dr_value), 32'(exp_dr(2)));
    endtask

    task automatic t_abort;
        salt = 3;
        power_cycle(3);
        pulse_set();
        step();
        repeat (9) step();
        chk("R8 running before abort", 32'(cal_busy), 1);
        power_on = 1'b0;
        step();
        chk("R8 busy cleared", 32'(cal_busy), 0);
        chk("R8 cal_bit cleared", 32'(cal_bit), 0);
        chk("R8 dr kept", 32'(dr_value), 32'(exp_dr(2)));
        repeat (3) step();
        chk("R8 no retry", 32'(cal_bit), 0);
        power_on = 1'b1;
        step();
    endtask

    task automatic t_abort_last;
        salt = 4;
        power_cycle(2);
        pulse_set();
        step();
        repeat (CAL - 1) step();
        chk("R8 in last busy cycle", 32'(cal_busy), 1);
        chk("R5 last slot strobe", 32'(cap_sample), 1);
        power_on = 1'b0;
        step();
        chk("R8 abort wins over load: dr", 32'(dr_value), 32'(exp_dr(2)));
        chk("R8 abort wins over load: cal_bit", 32'(cal_bit), 0);
        chk("R8 abort wins over load: busy", 32'(cal_busy), 0);
        power_on = 1'b1;
        step();
    endtask

    task automatic t_reset_ignored;
        int len, ns, bo, lk;
        salt = 5;
        power_cycle(2);
        pulse_set();
        step();
        repeat (5) step();
        pulse_set();
        chk("R9 still busy after extra set", 32'(cal_busy), 1);
        measure(len, ns, bo, lk);
        chk("R9 phase length unchanged", 32'(len), 32'(CAL - 6));
        repeat (5) step();
        chk("R9 no second phase busy", 32'(cal_busy), 0);
        chk("R9 no second phase cal_bit", 32'(cal_bit), 0);
        chk("R6 dr codes after extra set", 32'(dr_value), 32'(exp_dr(5)));
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_pending();
        t_abort();
        t_abort_last();
        t_reset_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule